// File: doc/BRIEF.md
# Mailbox Word Packet Framer

This block sits between a word-oriented command engine and a byte link to a mailbox whose storage is addressed in 32-bit words. For a write it takes words one at a time and wraps each one in a seven-byte slot: the four data bytes with the least significant byte first, two zero bytes, and an index marker. The slots are gathered into packets that each open with a fixed header byte. For a read it sends short fixed-size request packets that name a starting word. It then takes in the byte response that comes back and rebuilds the 32-bit words from it.

A transfer begins with a one-cycle `start` pulse that carries the mode and the word count. A write draws its words from the `in_*` stream. The framed bytes leave on the `tx_*` stream, which carries the length of the current packet and a last-byte flag. Response bytes arrive on the `rx_*` stream, and each rebuilt word appears for one cycle on `out_word`. Long transfers are split into several packets. The word index in each marker keeps counting across packet boundaries, so every marker holds an absolute word number. At the end of a transfer the block pulses `done`. If a response ends too early, it pulses `err` instead and drops the rest of the transfer.

Top module: `mbox_framer`

## Requirements
- R1: A start with a word count of zero pulses `done` on the cycle after `start` and sends no byte.
- R2: A write packet starts with header byte 0x01 and holds N slots, where N is the number of words in it. Its length is 1 + 7·N bytes. Every byte of the packet shows this length on `tx_len`, and `tx_last` is high on the final byte only. Each write word is taken exactly once.
- R3: Each slot byte has a fixed meaning. Bytes 0 to 3 are the word, least significant byte first. Bytes 4 and 5 are 0x00. Byte 6 is 0x44 plus the absolute word index since the start of the transfer, modulo 256.
- R4: A write packet holds at most 8 words. A longer write is sent as back-to-back packets of 8 words followed by one shorter packet.
- R5: Every read request is 8 bytes long. Byte 0 is the opcode: 0x02 for mode 2'b01 (status read) and 0x28 for mode 2'b10 or 2'b11 (block read). Bytes 1 to 6 are 0x00, and byte 7 is 0x44 plus the starting word offset. Mode 2'b00 selects a write.
- R6: A read request asks for at most 16 words. The next request is sent only after the whole response to the previous one has arrived, and its offset is larger by the number of words already fetched.
- R7: The response carries 4 bytes per word, least significant byte first. Each completed word appears on `out_word` with a one-cycle `out_valid` pulse on the cycle after its fourth byte is accepted. Words come out in address order.
- R8: After reset the block is idle and every strobe output is low. `done` pulses once, on the cycle after the final byte of the last write packet is accepted, or after the final response byte is accepted.
- R9: If `rx_last` comes with any byte other than the final byte of the current response, `err` pulses on the next cycle and `done` does not pulse. Words already completed are still delivered, a partly received word is dropped, and no further request is sent.
- R10: While `tx_ready` is low, no byte is consumed and no write word is taken. Any pattern of stalls on `tx_ready`, `in_valid` and `rx_valid` leaves the byte and word sequences unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a transfer; only acted on while idle |
| mode | input | 2 | Transfer kind: 00 write, 01 status read, 10/11 block read |
| count | input | CNT_W (16) | Number of words in the transfer |
| in_word | input | 32 | Write word |
| in_valid | input | 1 | Write word available |
| in_ready | output | 1 | Write word taken this cycle |
| tx_byte | output | 8 | Outgoing packet byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Link accepts the outgoing byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_len | output | LEN_W (6) | Byte length of the current packet |
| rx_byte | input | 8 | Response byte |
| rx_valid | input | 1 | Response byte valid |
| rx_last | input | 1 | Response ends with this byte |
| rx_ready | output | 1 | Block accepts response bytes |
| out_word | output | 32 | Rebuilt read word |
| out_valid | output | 1 | One-cycle strobe for `out_word` |
| done | output | 1 | Transfer completed |
| err | output | 1 | Response ended early |

## Verification
Writes are run with 1, 3, 8, 9 and 20 words. These sizes separate a single short packet, a packet filled exactly to its limit, and a split where the index marker has to carry into the next packet. Reads of 1, 16, 17 and 40 words, in both read modes and with the alternate block code, check the opcode choice and how the offset advances from one request to the next. Responses cut off in the middle of a word, on a word boundary and inside a later request check the error path. A separate check shows that the next transfer after an error starts cleanly. Zero-length starts, random stalls on every handshake, and random transfers of random sizes test that the byte stream is independent of timing.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [1:0] {
    XM_WRITE  = 2'd0,
    XM_STATUS = 2'd1,
    XM_BLOCK  = 2'd2,
    XM_BLOCK2 = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_RECV
  } fr_state_e;

  localparam logic [7:0] WR_HDR    = 8'h01;
  localparam logic [7:0] OP_STATUS = 8'h02;
  localparam logic [7:0] OP_BLOCK  = 8'h28;
  localparam logic [7:0] MARK_BASE = 8'h44;
  localparam int         RD_REQ_LEN = 8;
  localparam int         SLOT_LEN   = 7;

  // words carried by the next packet
  function automatic int unsigned chunk_of(input int unsigned left, input int unsigned lim);
    return (left < lim) ? left : lim;
  endfunction

  // byte length of a packet carrying ch words
  function automatic int unsigned pkt_len(input logic is_wr, input int unsigned ch);
    return is_wr ? (1 + SLOT_LEN * ch) : RD_REQ_LEN;
  endfunction

  function automatic logic [7:0] mark_of(input logic [7:0] idx_lo);
    return MARK_BASE + idx_lo;
  endfunction

  function automatic logic [7:0] read_opcode(input xfer_mode_e m);
    return (m == XM_STATUS) ? OP_STATUS : OP_BLOCK;
  endfunction

  // byte k of a word slot
  function automatic logic [7:0] slot_byte(input logic [2:0] k, input logic [31:0] w,
                                           input logic [7:0] mk);
    if (k < 3'd4)      return w[8*k +: 8];
    else if (k == 3'd6) return mk;
    else               return 8'h00;
  endfunction

endpackage

// File: rtl/mbx_tx_byte.sv
module mbx_tx_byte
  import mbx_pkg::*;
#(
  parameter int IDX_W = 16,
  parameter int LEN_W = 6
) (
  input  logic             is_wr,
  input  xfer_mode_e       md,
  input  logic [LEN_W-1:0] bidx,
  input  logic [2:0]       k,
  input  logic [31:0]      word,
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       byte_out
);

  always_comb begin
    if (is_wr) begin
      if (bidx == '0) byte_out = WR_HDR;
      else            byte_out = slot_byte(k, word, mark_of(idx[7:0]));
    end else begin
      if (bidx == '0)                        byte_out = read_opcode(md);
      else if (bidx == LEN_W'(RD_REQ_LEN-1)) byte_out = mark_of(idx[7:0]);
      else                                   byte_out = 8'h00;
    end
  end

endmodule

// File: rtl/mbx_rx_unpack.sv
module mbx_rx_unpack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_fire,
  input  logic [7:0]  byte_in,
  input  logic        clear,
  output logic [31:0] word_out,
  output logic        word_vld,
  output logic        word_end
);

  logic [1:0]  pos;
  logic [23:0] acc;

  assign word_end = byte_fire && (pos == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos      <= '0;
      acc      <= '0;
      word_out <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (word_end) begin
        word_out <= {byte_in, acc};
        word_vld <= 1'b1;
        pos      <= '0;
      end else if (clear) begin
        pos <= '0;
      end else if (byte_fire) begin
        acc <= {byte_in, acc[23:8]};
        pos <= pos + 2'd1;
      end
    end
  end

  // a word needs four bytes, so strobes never touch
  p_word_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld);

  // an early end drops the partly built word
  p_clear_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> pos == 2'd0);

endmodule

// File: rtl/mbox_framer.sv
module mbox_framer
  import mbx_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int WR_MAX = 8,
  parameter int RD_MAX = 16,
  localparam int LEN_W = $clog2(1 + SLOT_LEN * WR_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] count,
  input  logic [31:0]      in_word,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [7:0]       tx_byte,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic             tx_last,
  output logic [LEN_W-1:0] tx_len,
  input  logic [7:0]       rx_byte,
  input  logic             rx_valid,
  input  logic             rx_last,
  output logic             rx_ready,
  output logic [31:0]      out_word,
  output logic             out_valid,
  output logic             done,
  output logic             err
);

  localparam int CH_W = $clog2(((WR_MAX > RD_MAX) ? WR_MAX : RD_MAX) + 1);
  localparam int SQ_W = (WR_MAX > 1) ? $clog2(WR_MAX) : 1;

  fr_state_e        st;
  xfer_mode_e       md;
  logic [CNT_W-1:0] rem, offs;
  logic [CH_W-1:0]  chunk, wcnt;
  logic [LEN_W-1:0] bidx;
  logic [2:0]       kq;
  logic [SQ_W-1:0]  sq;
  logic [31:0]      wq;
  logic             done_q, err_q;

  // named internal events
  logic             is_wr, need_word, tx_fire, pkt_done, rx_fire;
  logic             word_end, resp_end, early, adv, xfer_end;
  logic [CNT_W-1:0] mark_idx, rem_after;

  assign is_wr     = (md == XM_WRITE);
  assign need_word = (st == ST_SEND) && is_wr && (bidx != '0) && (kq == 3'd0);
  assign tx_valid  = (st == ST_SEND) && (!need_word || in_valid);
  assign in_ready  = need_word && tx_ready;
  assign tx_len    = LEN_W'(pkt_len(is_wr, 32'(chunk)));
  assign tx_last   = tx_valid && (bidx == tx_len - LEN_W'(1));
  assign tx_fire   = tx_valid && tx_ready;
  assign pkt_done  = tx_fire && tx_last;
  assign rx_ready  = (st == ST_RECV);
  assign rx_fire   = rx_valid && rx_ready;
  assign resp_end  = word_end && (wcnt == chunk - CH_W'(1));
  assign early     = rx_fire && rx_last && !resp_end;
  assign adv       = is_wr ? pkt_done : resp_end;
  assign xfer_end  = adv && (rem == CNT_W'(chunk));
  assign rem_after = rem - CNT_W'(chunk);
  assign mark_idx  = is_wr ? (offs + CNT_W'(sq)) : offs;

  mbx_tx_byte #(.IDX_W(CNT_W), .LEN_W(LEN_W)) u_txb (
    .is_wr    (is_wr),
    .md       (md),
    .bidx     (bidx),
    .k        (kq),
    .word     (need_word ? in_word : wq),
    .idx      (mark_idx),
    .byte_out (tx_byte)
  );

  mbx_rx_unpack u_rxu (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_fire (rx_fire),
    .byte_in   (rx_byte),
    .clear     (early),
    .word_out  (out_word),
    .word_vld  (out_valid),
    .word_end  (word_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      md     <= XM_WRITE;
      rem    <= '0;
      offs   <= '0;
      chunk  <= '0;
      wcnt   <= '0;
      bidx   <= '0;
      kq     <= '0;
      sq     <= '0;
      wq     <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          md    <= xfer_mode_e'(mode);
          rem   <= count;
          offs  <= '0;
          bidx  <= '0;
          kq    <= '0;
          sq    <= '0;
          wcnt  <= '0;
          chunk <= CH_W'(chunk_of(32'(count),
                     (xfer_mode_e'(mode) == XM_WRITE) ? WR_MAX : RD_MAX));
          if (count == '0) done_q <= 1'b1;
          else             st     <= ST_SEND;
        end
        ST_SEND: if (tx_fire) begin
          if (need_word) wq <= in_word;
          bidx <= bidx + LEN_W'(1);
          if (is_wr && bidx != '0) begin
            if (kq == 3'd6) begin
              kq <= '0;
              sq <= sq + SQ_W'(1);
            end else begin
              kq <= kq + 3'd1;
            end
          end
          if (tx_last && !is_wr) begin
            st   <= ST_RECV;
            wcnt <= '0;
          end
        end
        ST_RECV: begin
          if (early) begin
            err_q <= 1'b1;
            st    <= ST_IDLE;
          end else if (word_end) begin
            wcnt <= wcnt + CH_W'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
      // packet or response finished: next packet or end of transfer
      if (adv) begin
        offs <= offs + CNT_W'(chunk);
        rem  <= rem_after;
        bidx <= '0;
        kq   <= '0;
        sq   <= '0;
        wcnt <= '0;
        if (xfer_end) begin
          done_q <= 1'b1;
          st     <= ST_IDLE;
        end else begin
          chunk <= CH_W'(chunk_of(32'(rem_after), is_wr ? WR_MAX : RD_MAX));
          st    <= ST_SEND;
        end
      end
    end
  end

  assign done = done_q;
  assign err  = err_q;

  p_zero_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && start && count == '0) |=> (done && !tx_valid));

  p_len_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_len <= LEN_W'(1 + SLOT_LEN * WR_MAX)));

  p_marker_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fire && is_wr && bidx != '0 && kq == 3'd6) |->
      (tx_byte == MARK_BASE + offs[7:0] + 8'(sq)));

  p_rd_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !is_wr) |-> (tx_len == LEN_W'(RD_REQ_LEN)));

  p_no_tx_while_recv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> !tx_valid);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (st == ST_IDLE && !tx_valid && !rx_ready));

  p_early_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    early |=> (err && !done && st == ST_IDLE));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !need_word) |=> (tx_valid && $stable(tx_byte)));

endmodule

// File: tb/test_mbox_framer.sv
module test_mbox_framer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  mode;
  logic [15:0] count;
  logic [31:0] in_word;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  tx_byte;
  logic        tx_valid, tx_ready, tx_last;
  logic [5:0]  tx_len;
  logic [7:0]  rx_byte;
  logic        rx_valid, rx_last, rx_ready;
  logic [31:0] out_word;
  logic        out_valid, done, err;

  always #4 clk = ~clk;

  mbox_framer i_mbox_framer (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .count(count),
    .in_word(in_word), .in_valid(in_valid), .in_ready(in_ready),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_last(tx_last), .tx_len(tx_len),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_last(rx_last), .rx_ready(rx_ready),
    .out_word(out_word), .out_valid(out_valid), .done(done), .err(err)
  );

  int errors = 0;
  int checks = 0;

  logic [31:0] wr [0:63];
  logic [31:0] rd [0:63];
  logic [7:0]  exp_b [0:1023];
  bit          exp_l [0:1023];
  int          exp_n [0:1023];
  int          ecnt;
  logic [7:0]  rq [0:63];
  int          rq_len, rq_pos, rbase, roff;
  bit          cut_here;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic void push(input logic [7:0] b, input int len);
    exp_b[ecnt] = b;
    exp_l[ecnt] = 1'b0;
    exp_n[ecnt] = len;
    ecnt++;
  endfunction

  // expected transmit stream, restated from the requirements
  function automatic void build(input int md, input int n, input int cut);
    int off = 0;
    ecnt = 0;
    while (off < n) begin
      int ch;
      if (md == 0) begin
        ch = (n - off < 8) ? n - off : 8;
        push(8'h01, 1 + 7 * ch);
        for (int s = 0; s < ch; s++) begin
          for (int b = 0; b < 4; b++) push(wr[off+s][8*b +: 8], 1 + 7 * ch);
          push(8'h00, 1 + 7 * ch);
          push(8'h00, 1 + 7 * ch);
          push(8'(8'h44 + off + s), 1 + 7 * ch);
        end
      end else begin
        ch = (n - off < 16) ? n - off : 16;
        if (cut >= 0 && 4 * off >= cut) break;
        push((md == 1) ? 8'h02 : 8'h28, 8);
        for (int b = 0; b < 6; b++) push(8'h00, 8);
        push(8'(8'h44 + off), 8);
      end
      exp_l[ecnt-1] = 1'b1;
      off += ch;
    end
  endfunction

  task automatic run_xfer(input int md, input int n, input int cut);
    int  tpos = 0, widx = 0, ridx = 0, tries = 0, exp_words;
    bit  ended = 0, exp_done = 0, exp_err = 0;
    string rtag;
    for (int i = 0; i < 64; i++) begin
      wr[i] = $urandom;
      rd[i] = $urandom;
    end
    build(md, n, cut);
    rq_len = 0; rq_pos = 0; rbase = 0; roff = 0; cut_here = 0;
    exp_words = (md == 0) ? 0 : ((cut >= 0) ? cut / 4 : n);
    rtag = (md == 0) ? "R4" : "R6";
    @(negedge clk);
    mode = 2'(md); count = 16'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (n == 0) exp_done = 1;
    while (!ended && tries < 20000) begin
      if (tries > 0) @(negedge clk);
      tries++;
      if (done || exp_done) begin
        chk(done == exp_done, (n == 0) ? "R1 done after zero count" : "R8 done timing", done, exp_done);
        if (done) ended = 1;
      end
      if (err || exp_err) begin
        chk(err == exp_err, "R9 err timing", err, exp_err);
        if (err) ended = 1;
      end
      if (out_valid) begin
        chk(ridx < exp_words && out_word == rd[ridx & 63], "R7 unpacked word", out_word, rd[ridx & 63]);
        ridx++;
      end
      exp_done = 0; exp_err = 0;
      if (ended) break;
      tx_ready = ($urandom_range(0, 3) != 0);
      in_valid = (md == 0) && (widx < n) && ($urandom_range(0, 3) != 0);
      in_word  = wr[widx & 63];
      rx_valid = (rq_pos < rq_len) && ($urandom_range(0, 3) != 0);
      rx_byte  = rq[rq_pos & 63];
      rx_last  = rx_valid && (rq_pos == rq_len - 1);
      #1;
      if (!tx_ready) chk(!in_ready, "R10 no word taken while stalled", in_ready, 0);
      if (tx_valid && tx_ready) begin
        if (tpos < ecnt) begin
          chk(tx_byte == exp_b[tpos], (md == 0) ? "R3 write byte" : "R5 request byte", tx_byte, exp_b[tpos]);
          chk(tx_len == 6'(exp_n[tpos]), "R2 packet length", tx_len, exp_n[tpos]);
          chk(tx_last == exp_l[tpos], "R2 last flag", tx_last, exp_l[tpos]);
        end else begin
          chk(0, {rtag, " extra byte"}, tpos, ecnt);
        end
        tpos++;
        if (md == 0 && tpos == ecnt) exp_done = 1;
        if (md != 0 && tx_last) begin
          int ch = (n - roff < 16) ? n - roff : 16;
          for (int j = 0; j < ch; j++)
            for (int b = 0; b < 4; b++) rq[4*j+b] = rd[roff+j][8*b +: 8];
          rq_len = 4 * ch; rq_pos = 0; cut_here = 0;
          if (cut >= 0 && rbase + rq_len > cut) begin
            rq_len = cut - rbase;
            cut_here = 1;
          end
          rbase += 4 * ch; roff += ch;
        end
      end
      if (in_valid && in_ready) widx++;
      if (rx_valid && rx_ready) begin
        rq_pos++;
        if (rq_pos == rq_len) begin
          if (cut_here) exp_err = 1;
          else if (roff == n) exp_done = 1;
        end
      end
    end
    in_valid = 0; rx_valid = 0; rx_last = 0; tx_ready = 1;
    chk(tpos == ecnt, {rtag, " byte count"}, tpos, ecnt);
    chk(ridx == exp_words, (cut >= 0) ? "R9 words kept" : "R7 word count", ridx, exp_words);
    if (md == 0) chk(widx == n, "R2 words taken", widx, n);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!tx_valid && !rx_ready && !done && !err,
          (cut >= 0) ? "R9 idle after error" : "R8 idle after end", {tx_valid, rx_ready, done, err}, 0);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; start = 0; mode = 0; count = 0; in_word = 0; in_valid = 0;
    tx_ready = 1; rx_byte = 0; rx_valid = 0; rx_last = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!tx_valid && !rx_ready && !in_ready && !done && !err && !out_valid,
        "R8 reset state", {tx_valid, rx_ready, in_ready, done, err, out_valid}, 0);
    run_xfer(0, 0, -1);   // R1
    run_xfer(2, 0, -1);   // R1
    run_xfer(0, 1, -1);   // R2 R3
    run_xfer(0, 3, -1);
    run_xfer(0, 8, -1);   // R4 full packet
    run_xfer(0, 9, -1);   // R4 split
    run_xfer(0, 20, -1);
    run_xfer(1, 1, -1);   // R5 status
    run_xfer(2, 16, -1);  // R6 full request
    run_xfer(2, 17, -1);  // R6 split
    run_xfer(3, 5, -1);   // R5 alternate block code
    run_xfer(1, 40, -1);
    run_xfer(2, 20, 10);  // R9 cut inside a word
    run_xfer(2, 20, 8);   // R9 cut on a word boundary
    run_xfer(2, 40, 70);  // R9 cut in second request
    run_xfer(0, 12, -1);  // clean after error
    for (int i = 0; i < 8; i++)
      run_xfer($urandom_range(0, 3), $urandom_range(1, 40), -1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule